// File: doc/BRIEF.md
# Virtual CPU Interrupt Class Lock Controller

This block arbitrates three maskable interrupt classes (input/output, external, machine check) among a group of virtual CPUs that share one set of execution resources. Each virtual CPU keeps its own enable bit per class. The machine-wide enable for a class is the conjunction of all those bits. Disabling a class therefore works as an exclusive lock. At most one CPU may hold a class disabled at a time. Any other CPU that asks to disable the same class is parked (suspended) in a per-class first-in first-out queue. It stays parked until every CPU ahead of it has released the class.

When an interrupt of a class is pending and the class is enabled machine-wide, the block names exactly one taker: the lowest-numbered CPU that is running, not suspended, and has the class enabled. All other CPUs continue undisturbed. After reset every CPU is stopped. An initial-load pulse starts the boot CPU alone. An activate command starts any further CPU by number.

Top module: `vcpu_irq_mask`

## Requirements
- R1: `sysEnable[c]` is the AND of bit `cpuMask[c*8+i]` over all CPUs i. Class code c is 0 for input/output, 1 for external and 2 for machine check. A mask bit of 1 means enabled.
- R2: While `sysEnable[c]` is 0, `takeValid[c]` stays 0 whatever `pending[c]` is.
- R3: A disable request (`reqDisable`=1) for a class with no holder clears the requester's bit at the next edge, and the requester becomes the holder. A disable request for a class held by another CPU raises the requester's `suspend` bit at the next edge and leaves its mask bit at 1.
- R4: An enable request (`reqDisable`=0) from the holder sets the holder's bit at the next edge. If CPUs are waiting, the oldest waiter becomes holder at that same edge: its bit clears and its `suspend` bit drops. With no waiters the class becomes enabled machine-wide.
- R5: Waiters receive a class in arrival order. Waiters arriving in the same cycle are ordered by ascending CPU number.
- R6: In the same cycle, `takeValid[c]` is 1 exactly when `pending[c]` is 1, `sysEnable[c]` is 1 and an eligible CPU exists. An eligible CPU is active, not suspended and has bit c set. `takeCpu[c*3 +: 3]` is then the lowest-numbered eligible CPU.
- R7: A stopped CPU is never named as taker. With no eligible CPU, `takeValid` is 0.
- R8: After reset, all CPUs are stopped, all mask bits are 1 and no CPU is suspended.
- R9: An `initLoad` pulse leaves only CPU 0 active at the next edge and stops all others. It takes precedence over a simultaneous activate command.
- R10: `activateValid` with a CPU number makes that CPU active at the next edge. All other CPUs keep their state.
- R11: The following requests have no effect on any output: requests from stopped or suspended CPUs, enable requests from a CPU that does not hold the class, disable requests from the current holder, and class code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 8 | Per-CPU mask change request strobe |
| reqDisable | input | 8 | Per-CPU request kind: 1 disable, 0 enable |
| reqClass | input | 16 | Per-CPU class code, CPU i at bits [2i+1:2i] |
| initLoad | input | 1 | Initial-load pulse, starts CPU 0 only |
| activateValid | input | 1 | Activate command strobe |
| activateCpu | input | 3 | CPU number to activate |
| pending | input | 3 | Pending interrupt line per class |
| sysEnable | output | 3 | Machine-wide enable per class |
| cpuMask | output | 24 | Per-CPU enable bits, class c CPU i at bit c*8+i |
| suspend | output | 8 | CPU parked waiting for a class |
| cpuActive | output | 8 | CPU running (1) or stopped (0) |
| takeValid | output | 3 | Interrupt of the class accepted this cycle |
| takeCpu | output | 9 | Taker CPU per class, class c at bits [3c+2:3c] |

## Verification
The embedded assertions check the following on every cycle:
- At most one CPU holds each class disabled.
- A waiter always has a holder ahead of it and keeps its own bit set.
- The queue occupancy matches the number of suspended CPUs for that class.
- An accepted interrupt always goes to an active, unsuspended CPU of an enabled class.
- Initial load and activation take effect one edge later.

Only the directed scenarios can show the rest:
- The hand-over order among several waiters.
- The exact taker number when lower-numbered CPUs are suspended or stopped.
- That ignored requests really leave every output unchanged.

// File: rtl/vcpu_irq_mask_pkg.sv
package vcpu_irq_mask_pkg;
  localparam int unsigned VCPU_COUNT  = 8;
  localparam int unsigned CLASS_COUNT = 3;
  localparam int unsigned VCPU_W      = $clog2(VCPU_COUNT);
  localparam int unsigned CLASS_W     = 2;
  localparam int unsigned BOOT_VCPU   = 0;

  typedef enum logic [CLASS_W-1:0] {
    CLS_IO   = 2'd0,
    CLS_EXT  = 2'd1,
    CLS_MCHK = 2'd2,
    CLS_NONE = 2'd3
  } irqClassE;

  // strobes from control to the lock datapath, one bit per class and CPU
  typedef struct packed {
    logic [CLASS_COUNT-1:0][VCPU_COUNT-1:0] lockReq;
    logic [CLASS_COUNT-1:0][VCPU_COUNT-1:0] unlockReq;
  } maskStrobeT;
endpackage

// File: rtl/vcpu_irq_mask_lock.sv
module vcpu_irq_mask_lock
  import vcpu_irq_mask_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [VCPU_COUNT-1:0] lockReq,
  input  logic [VCPU_COUNT-1:0] unlockReq,
  output logic [VCPU_COUNT-1:0] enBits,
  output logic [VCPU_COUNT-1:0] waiting
);
  localparam int unsigned CNT_W = VCPU_W + 1;

  logic                             holderValid, nHolderValid;
  logic [VCPU_W-1:0]                holderId, nHolderId;
  logic [VCPU_COUNT-1:0][VCPU_W-1:0] queue, nQueue;
  logic [CNT_W-1:0]                 qCnt, nQCnt;
  logic [VCPU_COUNT-1:0]            nEnBits, nWaiting;

  always_comb begin
    nHolderValid = holderValid;
    nHolderId    = holderId;
    nQueue       = queue;
    nQCnt        = qCnt;
    nEnBits      = enBits;
    nWaiting     = waiting;

    // release by the holder, hand over to the oldest waiter
    if (holderValid && unlockReq[holderId]) begin
      nEnBits[holderId] = 1'b1;
      if (qCnt != '0) begin
        nHolderId = queue[0];
        for (int k = 0; k < int'(VCPU_COUNT) - 1; k++) nQueue[k] = queue[k+1];
        nQueue[VCPU_COUNT-1] = '0;
        nQCnt = qCnt - CNT_W'(1);
        nWaiting[queue[0]] = 1'b0;
        nEnBits[queue[0]]  = 1'b0;
      end else begin
        nHolderValid = 1'b0;
      end
    end

    // new disable requests, ascending CPU number
    for (int i = 0; i < int'(VCPU_COUNT); i++) begin
      if (lockReq[i]) begin
        if (!nHolderValid) begin
          nHolderValid = 1'b1;
          nHolderId    = VCPU_W'(i);
          nEnBits[i]   = 1'b0;
        end else if (nHolderId != VCPU_W'(i) && nQCnt < CNT_W'(VCPU_COUNT)) begin
          nQueue[nQCnt[VCPU_W-1:0]] = VCPU_W'(i);
          nQCnt       = nQCnt + CNT_W'(1);
          nWaiting[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holderValid <= 1'b0;
      holderId    <= '0;
      queue       <= '0;
      qCnt        <= '0;
      enBits      <= '1;
      waiting     <= '0;
    end else begin
      holderValid <= nHolderValid;
      holderId    <= nHolderId;
      queue       <= nQueue;
      qCnt        <= nQCnt;
      enBits      <= nEnBits;
      waiting     <= nWaiting;
    end
  end

  // R3
  single_holder_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~enBits) <= 1);
  // R3
  waiter_bit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waiting & ~enBits) == '0);
  // R4
  waiter_has_holder_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|waiting) |-> (holderValid && !enBits[holderId]));
  // R5
  queue_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    qCnt == CNT_W'($countones(waiting)));
endmodule

// File: rtl/vcpu_irq_mask_bank.sv
module vcpu_irq_mask_bank
  import vcpu_irq_mask_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  maskStrobeT                             strobe,
  output logic [CLASS_COUNT-1:0][VCPU_COUNT-1:0] maskBits,
  output logic [CLASS_COUNT-1:0]                 sysEnable,
  output logic [VCPU_COUNT-1:0]                  suspend
);
  logic [CLASS_COUNT-1:0][VCPU_COUNT-1:0] waitBits;

  for (genvar c = 0; c < int'(CLASS_COUNT); c++) begin : gClass
    vcpu_irq_mask_lock uLock (
      .clk      (clk),
      .rstN     (rstN),
      .lockReq  (strobe.lockReq[c]),
      .unlockReq(strobe.unlockReq[c]),
      .enBits   (maskBits[c]),
      .waiting  (waitBits[c])
    );
    assign sysEnable[c] = &maskBits[c];
  end

  always_comb begin
    suspend = '0;
    for (int c = 0; c < int'(CLASS_COUNT); c++) suspend |= waitBits[c];
  end

  // R3: a CPU waits on one class at most
  one_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (waitBits[0] & waitBits[1]) == '0 && (waitBits[0] & waitBits[2]) == '0 &&
    (waitBits[1] & waitBits[2]) == '0);
endmodule

// File: rtl/vcpu_irq_mask_ctrl.sv
module vcpu_irq_mask_ctrl
  import vcpu_irq_mask_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [VCPU_COUNT-1:0]                  reqValid,
  input  logic [VCPU_COUNT-1:0]                  reqDisable,
  input  logic [VCPU_COUNT-1:0][CLASS_W-1:0]     reqClass,
  input  logic                                   initLoad,
  input  logic                                   activateValid,
  input  logic [VCPU_W-1:0]                      activateCpu,
  input  logic [CLASS_COUNT-1:0]                 pending,
  input  logic [CLASS_COUNT-1:0][VCPU_COUNT-1:0] maskBits,
  input  logic [CLASS_COUNT-1:0]                 sysEnable,
  input  logic [VCPU_COUNT-1:0]                  suspend,
  output maskStrobeT                             strobe,
  output logic [VCPU_COUNT-1:0]                  cpuActive,
  output logic [CLASS_COUNT-1:0]                 takeValid,
  output logic [CLASS_COUNT-1:0][VCPU_W-1:0]     takeCpu
);
  logic [VCPU_COUNT-1:0] usable;
  assign usable = cpuActive & ~suspend;

  // run state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuActive <= '0;
    end else if (initLoad) begin
      cpuActive <= VCPU_COUNT'(1) << BOOT_VCPU;
    end else if (activateValid) begin
      cpuActive[activateCpu] <= 1'b1;
    end
  end

  // request decode into strobes
  always_comb begin
    strobe = '0;
    for (int i = 0; i < int'(VCPU_COUNT); i++) begin
      for (int c = 0; c < int'(CLASS_COUNT); c++) begin
        if (reqValid[i] && usable[i] && reqClass[i] == CLASS_W'(c)) begin
          if (reqDisable[i]) strobe.lockReq[c][i]   = 1'b1;
          else               strobe.unlockReq[c][i] = 1'b1;
        end
      end
    end
  end

  // taker selection: lowest eligible CPU per class
  always_comb begin
    for (int c = 0; c < int'(CLASS_COUNT); c++) begin
      logic found;
      found      = 1'b0;
      takeCpu[c] = '0;
      for (int i = 0; i < int'(VCPU_COUNT); i++) begin
        if (!found && usable[i] && maskBits[c][i]) begin
          found      = 1'b1;
          takeCpu[c] = VCPU_W'(i);
        end
      end
      takeValid[c] = pending[c] && sysEnable[c] && found;
    end
  end

  // R9
  boot_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    initLoad |=> ($countones(cpuActive) == 1 && cpuActive[BOOT_VCPU]));
  // R10
  activate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (activateValid && !initLoad) |=> cpuActive[$past(activateCpu)]);
  // R2
  take_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeValid & ~(sysEnable & pending)) == '0);

  for (genvar c = 0; c < int'(CLASS_COUNT); c++) begin : gTakeChk
    // R7
    taker_running_chk: assert property (@(posedge clk) disable iff (!rstN)
      takeValid[c] |-> (cpuActive[takeCpu[c]] && !suspend[takeCpu[c]]));
  end
endmodule

// File: rtl/vcpu_irq_mask.sv
module vcpu_irq_mask
  import vcpu_irq_mask_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [VCPU_COUNT-1:0]             reqValid,
  input  logic [VCPU_COUNT-1:0]             reqDisable,
  input  logic [VCPU_COUNT*CLASS_W-1:0]     reqClass,
  input  logic                              initLoad,
  input  logic                              activateValid,
  input  logic [VCPU_W-1:0]                 activateCpu,
  input  logic [CLASS_COUNT-1:0]            pending,
  output logic [CLASS_COUNT-1:0]            sysEnable,
  output logic [CLASS_COUNT*VCPU_COUNT-1:0] cpuMask,
  output logic [VCPU_COUNT-1:0]             suspend,
  output logic [VCPU_COUNT-1:0]             cpuActive,
  output logic [CLASS_COUNT-1:0]            takeValid,
  output logic [CLASS_COUNT*VCPU_W-1:0]     takeCpu
);
  maskStrobeT                             strobe;
  logic [CLASS_COUNT-1:0][VCPU_COUNT-1:0] maskBits;
  logic [VCPU_COUNT-1:0][CLASS_W-1:0]     reqClassArr;
  logic [CLASS_COUNT-1:0][VCPU_W-1:0]     takeCpuArr;

  assign reqClassArr = reqClass;
  assign cpuMask     = maskBits;
  assign takeCpu     = takeCpuArr;

  vcpu_irq_mask_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqDisable   (reqDisable),
    .reqClass     (reqClassArr),
    .initLoad     (initLoad),
    .activateValid(activateValid),
    .activateCpu  (activateCpu),
    .pending      (pending),
    .maskBits     (maskBits),
    .sysEnable    (sysEnable),
    .suspend      (suspend),
    .strobe       (strobe),
    .cpuActive    (cpuActive),
    .takeValid    (takeValid),
    .takeCpu      (takeCpuArr)
  );

  vcpu_irq_mask_bank uBank (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .maskBits (maskBits),
    .sysEnable(sysEnable),
    .suspend  (suspend)
  );
endmodule

// File: tb/tb_vcpu_irq_mask.sv
module tb_vcpu_irq_mask;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  reqValid = '0;
  logic [7:0]  reqDisable = '0;
  logic [15:0] reqClass = '0;
  logic        initLoad = 1'b0;
  logic        activateValid = 1'b0;
  logic [2:0]  activateCpu = '0;
  logic [2:0]  pending = '0;
  logic [2:0]  sysEnable;
  logic [23:0] cpuMask;
  logic [7:0]  suspend;
  logic [7:0]  cpuActive;
  logic [2:0]  takeValid;
  logic [8:0]  takeCpu;

  int checks = 0;
  int errors = 0;

  vcpu_irq_mask dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    reqValid = '0; reqDisable = '0; reqClass = '0;
    initLoad = 1'b0; activateValid = 1'b0;
  endtask

  task automatic req(int cpu, bit dis, int cls);
    reqValid[cpu] = 1'b1;
    reqDisable[cpu] = dis;
    reqClass[cpu*2 +: 2] = 2'(cls);
  endtask

  task automatic activate(int cpu);
    activateValid = 1'b1; activateCpu = 3'(cpu); tick();
  endtask

  function automatic logic [7:0] maskOf(int cls);
    return cpuMask[cls*8 +: 8];
  endfunction

  task automatic t_reset();
    chk("R8", "active after reset", cpuActive, 8'h00);
    chk("R8", "suspend after reset", suspend, 8'h00);
    chk("R8", "masks after reset", cpuMask, 24'hFFFFFF);
    chk("R1", "sysEnable after reset", sysEnable, 3'b111);
  endtask

  task automatic t_stopped();
    req(2, 1, 0); tick();
    chk("R11", "stopped CPU request ignored", cpuMask, 24'hFFFFFF);
    pending = 3'b111; #1;
    chk("R7", "no taker while all stopped", takeValid, 3'b000);
    pending = '0;
  endtask

  task automatic t_start();
    activate(3);
    chk("R10", "activate CPU3", cpuActive, 8'h08);
    initLoad = 1'b1; activateValid = 1'b1; activateCpu = 3'd5; tick();
    chk("R9", "initial load boot only", cpuActive, 8'h01);
    for (int k = 1; k < 5; k++) activate(k);
    chk("R10", "CPUs 0..4 active", cpuActive, 8'h1F);
  endtask

  task automatic t_take_basic();
    pending = 3'b111; #1;
    chk("R6", "all classes taken", takeValid, 3'b111);
    chk("R6", "taker CPU0 each class", takeCpu, 9'h000);
    pending = '0;
  endtask

  task automatic t_lock_chain();
    req(1, 1, 0); tick();
    chk("R3", "CPU1 holds io", maskOf(0), 8'hFD);
    chk("R1", "io disabled system-wide", sysEnable, 3'b110);
    pending = 3'b011; #1;
    chk("R2", "io held back", takeValid, 3'b010);
    chk("R6", "ext taker CPU0", takeCpu[5:3], 3'd0);
    pending = '0;
    req(3, 1, 0); req(2, 1, 0); tick();
    chk("R3", "CPU2 CPU3 suspended", suspend, 8'h0C);
    chk("R3", "waiters keep bits", maskOf(0), 8'hFD);
    req(4, 1, 0); tick();
    chk("R3", "CPU4 suspended", suspend, 8'h1C);
    req(2, 0, 0); req(0, 0, 0); tick();
    chk("R11", "non-holder enable ignored", maskOf(0), 8'hFD);
    chk("R11", "suspended request ignored", suspend, 8'h1C);
    req(1, 0, 0); tick();
    chk("R4", "hand-over to CPU2", maskOf(0), 8'hFB);
    chk("R5", "CPU2 first of same-cycle pair", suspend, 8'h18);
    req(2, 0, 0); tick();
    chk("R5", "then CPU3", maskOf(0), 8'hF7);
    chk("R5", "CPU4 still waits", suspend, 8'h10);
    req(3, 0, 0); tick();
    chk("R5", "then CPU4", maskOf(0), 8'hEF);
    chk("R4", "nobody waits", suspend, 8'h00);
    req(4, 0, 0); tick();
    chk("R4", "io enabled again", sysEnable, 3'b111);
  endtask

  task automatic t_take_skip();
    req(1, 1, 1); tick();
    req(0, 1, 1); tick();
    chk("R3", "CPU0 waits on ext", suspend, 8'h01);
    pending = 3'b101; #1;
    chk("R6", "io taker skips suspended CPU0", takeCpu[2:0], 3'd1);
    chk("R6", "mchk taker CPU1", takeCpu[8:6], 3'd1);
    chk("R2", "ext blocked", takeValid, 3'b101);
    pending = '0;
    req(1, 0, 1); tick();
    chk("R4", "CPU0 now holds ext", maskOf(1), 8'hFE);
    pending = 3'b001; #1;
    chk("R6", "io taker CPU0 again", takeCpu[2:0], 3'd0);
    pending = '0;
    req(0, 1, 1); tick();
    chk("R11", "holder re-disable ignored", suspend, 8'h00);
    req(0, 1, 3); tick();
    chk("R11", "class code 3 ignored", cpuMask, 24'hFFFEFF);
    req(0, 0, 1); tick();
    chk("R1", "all enabled at end", sysEnable, 3'b111);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    t_reset();
    t_stopped();
    t_start();
    t_take_basic();
    t_lock_chain();
    t_take_skip();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule